// File: doc/BRIEF.md
# Interleaved Superword Memory Access Controller

The block sits between four 128-bit requesters and a memory made of 32 low-order interleaved banks holding 512-bit superwords. The requesters are a write stream, two read streams, and one shared port that carries instruction fetch, I/O and control-vector traffic and can either read or write. Each port address names one superword plus one of its four 128-bit quarters (beats). The internal path to memory is one superword wide, so at most one access starts per cycle. Each access occupies its bank for a long busy window, and other banks stay available during that window.

Each cycle the controller looks at every requesting port and checks whether that port's target bank is idle. It grants the highest-priority port whose bank is idle. A port that is not granted keeps its request up and tries again in the next cycle. A write replaces one beat of the superword and leaves the other three beats as they were. A read returns its beat on the port that asked for it, with a one-cycle valid pulse, a fixed bank latency after the grant. Because every read has the same latency, each port receives its data in the order its reads were granted.

Top module: `sw_bank_ctrl`

## Requirements
- R1: With reset released and no request raised, no grant and no read-valid is asserted, and all read data outputs are zero.
- R2: A port address splits into three fields. Bits [1:0] select the 128-bit beat. Bits [BANK_W+1:2] select the bank (bits [6:2] with defaults). The bits above bit 1 form the superword address, so consecutive superwords fall in consecutive banks.
- R3: At most one port is granted per cycle. A grant goes only to a port whose request is high and whose bank is idle. A request that is refused and held high is granted once its bank becomes free.
- R4: Among ports whose banks are idle, the priority order is write port, then read port 0, then read port 1, then the shared port.
- R5: A higher-priority port whose bank is busy does not block a lower-priority port whose bank is idle; the lower-priority port is granted in the same cycle.
- R6: After a grant in cycle c, the same bank refuses every access in cycles c+1 through c+BUSY and can be granted again in cycle c+BUSY+1.
- R7: A write stores its 128-bit beat and leaves the other three beats of that superword unchanged.
- R8: A read granted in cycle c raises its port's valid in cycle c+BUSY, for exactly one cycle. The data in that cycle is the current content of the addressed beat.
- R9: Read data and valid appear only on the port that issued the read, in the order that port's reads were granted. A read port whose valid is low drives zero data.
- R10: On the shared port, shWrite=1 makes a granted access a write of shWData. shWrite=0 makes it a read that returns on shValid/shData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | Write stream request |
| wrAddr | input | SW_ADDR_W+2 (10) | Write stream superword and beat address |
| wrData | input | DW (128) | Write stream beat data |
| wrGnt | output | 1 | Write stream granted this cycle |
| rd0Req | input | 1 | Read stream 0 request |
| rd0Addr | input | SW_ADDR_W+2 (10) | Read stream 0 address |
| rd0Gnt | output | 1 | Read stream 0 granted this cycle |
| rd0Valid | output | 1 | Read stream 0 return pulse |
| rd0Data | output | DW (128) | Read stream 0 return data |
| rd1Req | input | 1 | Read stream 1 request |
| rd1Addr | input | SW_ADDR_W+2 (10) | Read stream 1 address |
| rd1Gnt | output | 1 | Read stream 1 granted this cycle |
| rd1Valid | output | 1 | Read stream 1 return pulse |
| rd1Data | output | DW (128) | Read stream 1 return data |
| shReq | input | 1 | Shared port request |
| shWrite | input | 1 | Shared port access is a write |
| shAddr | input | SW_ADDR_W+2 (10) | Shared port address |
| shWData | input | DW (128) | Shared port write data |
| shGnt | output | 1 | Shared port granted this cycle |
| shValid | output | 1 | Shared port read return pulse |
| shData | output | DW (128) | Shared port read return data |

## Verification
The hardest situation to create is four ports that all become eligible in the same cycle, with the outcome depending on which banks are busy. That calls for exact control over bank state, and stream traffic alone rarely gives it. The bench first waits until every bank is idle. It then starts all four ports on the same negative edge, once with all four aimed at one bank and once with each aimed at its own bank. In the shared-bank case the grants must come out one full busy window apart, in priority order. In the separate-bank case they must come out in consecutive cycles. A further step leaves the write port stalled on a bank it has just used and checks that the shared port gets past it in the very next cycle. Beyond these directed steps, the bench writes every beat of every superword from two ports at once. It then reads all of them back from three ports whose address ranges collide bank by bank. Each return is checked for its exact cycle and for its data.

// File: rtl/sw_bank_pkg.sv
package sw_bank_pkg;

  localparam int NUM_PORTS = 4;
  localparam int BEAT_W    = 2;
  localparam int NUM_BEATS = 1 << BEAT_W;

  // Port index doubles as priority rank: lower index wins.
  typedef enum logic [1:0] {
    PORT_WR  = 2'd0,
    PORT_RD0 = 2'd1,
    PORT_RD1 = 2'd2,
    PORT_SH  = 2'd3
  } portSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     wrEn;          // commit a beat write this cycle
    logic     wrFromShared;  // write data comes from the shared port
    logic     retValid;      // a read retires this cycle
    portSel_e retPort;       // port receiving the retiring read
  } bankStrobe_t;

endpackage

// File: rtl/sw_bank_ctl.sv
module sw_bank_ctl
  import sw_bank_pkg::*;
#(
  parameter int SW_ADDR_W = 8,
  parameter int BANK_W    = 5,
  parameter int BUSY      = 32
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic [NUM_PORTS-1:0]                         req,
  input  logic [NUM_PORTS-1:0][SW_ADDR_W+BEAT_W-1:0]   addr,
  input  logic                                         shWrite,
  output logic [NUM_PORTS-1:0]                         gnt,
  output bankStrobe_t                                  strobe,
  output logic [SW_ADDR_W+BEAT_W-1:0]                  wrAddrSel,
  output logic [SW_ADDR_W+BEAT_W-1:0]                  retAddr
);

  localparam int AW    = SW_ADDR_W + BEAT_W;
  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(BUSY + 1);
  localparam int LAT   = BUSY;

  logic [CNT_W-1:0]            busyCnt [NBANK];
  logic [NUM_PORTS-1:0]        elig;
  logic [NUM_PORTS-1:0][BANK_W-1:0] portBank;
  portSel_e                    gIdx;
  logic                        anyGnt;
  logic [AW-1:0]               gAddr;
  logic [BANK_W-1:0]           gBank;
  logic                        rdGnt;

  // Read return pipeline: fixed depth equal to the bank latency.
  logic [LAT-1:0]              pV;
  portSel_e                    pPort [LAT];
  logic [AW-1:0]               pAddr [LAT];

  // Per-port bank decode and eligibility.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign portBank[p] = addr[p][BEAT_W +: BANK_W];
    assign elig[p]     = req[p] && (busyCnt[portBank[p]] == '0);
  end

  // Lowest set bit of elig = highest-priority eligible port.
  assign gnt    = elig & (~elig + 1'b1);
  assign anyGnt = |gnt;

  always_comb begin
    if (gnt[PORT_WR])       gIdx = PORT_WR;
    else if (gnt[PORT_RD0]) gIdx = PORT_RD0;
    else if (gnt[PORT_RD1]) gIdx = PORT_RD1;
    else                    gIdx = PORT_SH;
  end

  assign gAddr = addr[gIdx];
  assign gBank = gAddr[BEAT_W +: BANK_W];
  assign rdGnt = gnt[PORT_RD0] | gnt[PORT_RD1] | (gnt[PORT_SH] & ~shWrite);

  // Bank busy down-counters.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBANK; b++) busyCnt[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (anyGnt && gBank == BANK_W'(b)) busyCnt[b] <= CNT_W'(BUSY);
        else if (busyCnt[b] != '0)         busyCnt[b] <= busyCnt[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pV <= '0;
    else       pV <= {pV[LAT-2:0], rdGnt};
  end

  always_ff @(posedge clk) begin
    pPort[0] <= gIdx;
    pAddr[0] <= gAddr;
    for (int i = 1; i < LAT; i++) begin
      pPort[i] <= pPort[i-1];
      pAddr[i] <= pAddr[i-1];
    end
  end

  always_comb begin
    strobe.wrEn         = gnt[PORT_WR] | (gnt[PORT_SH] & shWrite);
    strobe.wrFromShared = gnt[PORT_SH];
    strobe.retValid     = pV[LAT-1];
    strobe.retPort      = pPort[LAT-1];
  end

  assign wrAddrSel = gAddr;
  assign retAddr   = pAddr[LAT-1];

endmodule

// File: rtl/sw_bank_dp.sv
module sw_bank_dp
  import sw_bank_pkg::*;
#(
  parameter int SW_ADDR_W = 8,
  parameter int DW        = 128
) (
  input  logic                          clk,
  input  bankStrobe_t                   strobe,
  input  logic [SW_ADDR_W+BEAT_W-1:0]   wrAddrSel,
  input  logic [SW_ADDR_W+BEAT_W-1:0]   retAddr,
  input  logic [DW-1:0]                 wrData,
  input  logic [DW-1:0]                 shWData,
  output logic                          rd0Valid,
  output logic [DW-1:0]                 rd0Data,
  output logic                          rd1Valid,
  output logic [DW-1:0]                 rd1Data,
  output logic                          shValid,
  output logic [DW-1:0]                 shData
);

  localparam int NSW = 1 << SW_ADDR_W;

  logic [NUM_BEATS-1:0][DW-1:0] mem [NSW];
  logic [DW-1:0]                retBeat;

  // Beat-granular write into the superword row.
  always_ff @(posedge clk) begin
    if (strobe.wrEn)
      mem[wrAddrSel[SW_ADDR_W+BEAT_W-1:BEAT_W]][wrAddrSel[BEAT_W-1:0]] <=
        strobe.wrFromShared ? shWData : wrData;
  end

  assign retBeat = mem[retAddr[SW_ADDR_W+BEAT_W-1:BEAT_W]][retAddr[BEAT_W-1:0]];

  assign rd0Valid = strobe.retValid && strobe.retPort == PORT_RD0;
  assign rd1Valid = strobe.retValid && strobe.retPort == PORT_RD1;
  assign shValid  = strobe.retValid && strobe.retPort == PORT_SH;

  assign rd0Data = rd0Valid ? retBeat : '0;
  assign rd1Data = rd1Valid ? retBeat : '0;
  assign shData  = shValid  ? retBeat : '0;

endmodule

// File: rtl/sw_bank_ctrl.sv
module sw_bank_ctrl
  import sw_bank_pkg::*;
#(
  parameter int SW_ADDR_W = 8,
  parameter int BANK_W    = 5,
  parameter int DW        = 128,
  parameter int BUSY      = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrReq,
  input  logic [SW_ADDR_W+BEAT_W-1:0]  wrAddr,
  input  logic [DW-1:0]                wrData,
  output logic                         wrGnt,
  input  logic                         rd0Req,
  input  logic [SW_ADDR_W+BEAT_W-1:0]  rd0Addr,
  output logic                         rd0Gnt,
  output logic                         rd0Valid,
  output logic [DW-1:0]                rd0Data,
  input  logic                         rd1Req,
  input  logic [SW_ADDR_W+BEAT_W-1:0]  rd1Addr,
  output logic                         rd1Gnt,
  output logic                         rd1Valid,
  output logic [DW-1:0]                rd1Data,
  input  logic                         shReq,
  input  logic                         shWrite,
  input  logic [SW_ADDR_W+BEAT_W-1:0]  shAddr,
  input  logic [DW-1:0]                shWData,
  output logic                         shGnt,
  output logic                         shValid,
  output logic [DW-1:0]                shData
);

  localparam int AW = SW_ADDR_W + BEAT_W;

  bankStrobe_t                    strobe;
  logic [AW-1:0]                  wrAddrSel;
  logic [AW-1:0]                  retAddr;
  logic [NUM_PORTS-1:0]           gnt;

  sw_bank_ctl #(.SW_ADDR_W(SW_ADDR_W), .BANK_W(BANK_W), .BUSY(BUSY)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .req       ({shReq, rd1Req, rd0Req, wrReq}),
    .addr      ({shAddr, rd1Addr, rd0Addr, wrAddr}),
    .shWrite   (shWrite),
    .gnt       (gnt),
    .strobe    (strobe),
    .wrAddrSel (wrAddrSel),
    .retAddr   (retAddr)
  );

  assign wrGnt  = gnt[PORT_WR];
  assign rd0Gnt = gnt[PORT_RD0];
  assign rd1Gnt = gnt[PORT_RD1];
  assign shGnt  = gnt[PORT_SH];

  sw_bank_dp #(.SW_ADDR_W(SW_ADDR_W), .DW(DW)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .wrAddrSel (wrAddrSel),
    .retAddr   (retAddr),
    .wrData    (wrData),
    .shWData   (shWData),
    .rd0Valid  (rd0Valid),
    .rd0Data   (rd0Data),
    .rd1Valid  (rd1Valid),
    .rd1Data   (rd1Data),
    .shValid   (shValid),
    .shData    (shData)
  );

endmodule

// File: rtl/sw_bank_chk.sv
module sw_bank_chk #(
  parameter int SW_ADDR_W = 8,
  parameter int BANK_W    = 5,
  parameter int BUSY      = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrReq,
  input logic [SW_ADDR_W+1:0]     wrAddr,
  input logic                     wrGnt,
  input logic                     rd0Req,
  input logic [SW_ADDR_W+1:0]     rd0Addr,
  input logic                     rd0Gnt,
  input logic                     rd0Valid,
  input logic                     rd1Req,
  input logic [SW_ADDR_W+1:0]     rd1Addr,
  input logic                     rd1Gnt,
  input logic                     rd1Valid,
  input logic                     shReq,
  input logic                     shWrite,
  input logic [SW_ADDR_W+1:0]     shAddr,
  input logic                     shGnt,
  input logic                     shValid
);

  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(BUSY + 1);
  localparam int OUT_W = $clog2(BUSY + 2) + 1;

  logic [CNT_W-1:0]  watch [NBANK];
  logic [3:0]        gnts, reqs;
  logic [BANK_W-1:0] bWr, bRd0, bRd1, bSh, gBank;
  logic              wrBusy, rd0Busy, rd1Busy, shBusy, gBusy;
  logic              rdIssue;
  logic [2:0]        rets;
  logic [OUT_W-1:0]  outstanding;

  assign gnts  = {shGnt, rd1Gnt, rd0Gnt, wrGnt};
  assign reqs  = {shReq, rd1Req, rd0Req, wrReq};
  assign bWr   = wrAddr[2 +: BANK_W];
  assign bRd0  = rd0Addr[2 +: BANK_W];
  assign bRd1  = rd1Addr[2 +: BANK_W];
  assign bSh   = shAddr[2 +: BANK_W];
  assign gBank = wrGnt ? bWr : rd0Gnt ? bRd0 : rd1Gnt ? bRd1 : bSh;
  assign wrBusy  = watch[bWr]  != '0;
  assign rd0Busy = watch[bRd0] != '0;
  assign rd1Busy = watch[bRd1] != '0;
  assign shBusy  = watch[bSh]  != '0;
  assign gBusy   = watch[gBank] != '0;
  assign rdIssue = rd0Gnt | rd1Gnt | (shGnt & ~shWrite);
  assign rets    = {shValid, rd1Valid, rd0Valid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBANK; b++) watch[b] <= '0;
      outstanding <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if ((|gnts) && gBank == BANK_W'(b)) watch[b] <= CNT_W'(BUSY);
        else if (watch[b] != '0)           watch[b] <= watch[b] - 1'b1;
      end
      outstanding <= outstanding + OUT_W'(rdIssue) - OUT_W'(|rets);
    end
  end

  AST_ONE_GRANT:    assert property (@(posedge clk) disable iff (!rstN) $onehot0(gnts)); // R3
  AST_GNT_HAS_REQ:  assert property (@(posedge clk) disable iff (!rstN) (gnts & ~reqs) == 4'b0); // R3
  AST_BANK_IDLE:    assert property (@(posedge clk) disable iff (!rstN) (|gnts) |-> !gBusy); // R6
  AST_PRIO_WR:      assert property (@(posedge clk) disable iff (!rstN)
                      (wrReq && (rd0Gnt || rd1Gnt || shGnt)) |-> wrBusy); // R4
  AST_PRIO_RD0:     assert property (@(posedge clk) disable iff (!rstN)
                      (rd0Req && (rd1Gnt || shGnt)) |-> rd0Busy); // R4
  AST_PRIO_RD1:     assert property (@(posedge clk) disable iff (!rstN)
                      (rd1Req && shGnt) |-> rd1Busy); // R4
  AST_IDLE_SERVED:  assert property (@(posedge clk) disable iff (!rstN)
                      (shReq && !shBusy) |-> (|gnts)); // R5
  AST_RET_ONEHOT:   assert property (@(posedge clk) disable iff (!rstN) $onehot0(rets)); // R9
  AST_NO_SPURIOUS:  assert property (@(posedge clk) disable iff (!rstN) (|rets) |-> outstanding != '0); // R8

endmodule

bind sw_bank_ctrl sw_bank_chk #(
  .SW_ADDR_W (SW_ADDR_W),
  .BANK_W    (BANK_W),
  .BUSY      (BUSY)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrReq    (wrReq),
  .wrAddr   (wrAddr),
  .wrGnt    (wrGnt),
  .rd0Req   (rd0Req),
  .rd0Addr  (rd0Addr),
  .rd0Gnt   (rd0Gnt),
  .rd0Valid (rd0Valid),
  .rd1Req   (rd1Req),
  .rd1Addr  (rd1Addr),
  .rd1Gnt   (rd1Gnt),
  .rd1Valid (rd1Valid),
  .shReq    (shReq),
  .shWrite  (shWrite),
  .shAddr   (shAddr),
  .shGnt    (shGnt),
  .shValid  (shValid)
);

// File: tb/sw_bank_ctrl_tb.sv
`timescale 1ns/1ps
module sw_bank_ctrl_tb;

  localparam int SWA  = 8;
  localparam int AW   = SWA + 2;
  localparam int DW   = 128;
  localparam int BUSY = 32;
  localparam int NSW  = 1 << SWA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 0, rd0Req = 0, rd1Req = 0, shReq = 0, shWrite = 0;
  logic [AW-1:0] wrAddr = '0, rd0Addr = '0, rd1Addr = '0, shAddr = '0;
  logic [DW-1:0] wrData = '0, shWData = '0;
  logic wrGnt, rd0Gnt, rd1Gnt, shGnt, rd0Valid, rd1Valid, shValid;
  logic [DW-1:0] rd0Data, rd1Data, shData;

  int cmpCnt = 0;
  int errCnt = 0;
  int cyc = 0;

  logic [DW-1:0] model [NSW*4];
  int            dueQ [3][$];
  logic [DW-1:0] datQ [3][$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sw_bank_ctrl #(.SW_ADDR_W(SWA), .BANK_W(5), .DW(DW), .BUSY(BUSY)) u_dut (
    .clk(clk), .rstN(rstN),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrGnt(wrGnt),
    .rd0Req(rd0Req), .rd0Addr(rd0Addr), .rd0Gnt(rd0Gnt), .rd0Valid(rd0Valid), .rd0Data(rd0Data),
    .rd1Req(rd1Req), .rd1Addr(rd1Addr), .rd1Gnt(rd1Gnt), .rd1Valid(rd1Valid), .rd1Data(rd1Data),
    .shReq(shReq), .shWrite(shWrite), .shAddr(shAddr), .shWData(shWData), .shGnt(shGnt),
    .shValid(shValid), .shData(shData)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {32'(a * 37 + salt), 32'(a ^ 32'h5A5A_0000), 32'(~a), 32'((a << 3) + salt)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    cmpCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
  endtask

  // All tasks start and end at a negative edge; requests are held until granted (R3).
  task automatic doWr(input int a, input logic [DW-1:0] d, output int g);
    wrReq = 1; wrAddr = AW'(a); wrData = d; #1;
    while (!wrGnt) begin @(negedge clk); #1; end
    g = cyc; model[a] = d;
    @(negedge clk); wrReq = 0;
  endtask

  task automatic doShWr(input int a, input logic [DW-1:0] d, output int g); // R10
    shReq = 1; shWrite = 1; shAddr = AW'(a); shWData = d; #1;
    while (!shGnt) begin @(negedge clk); #1; end
    g = cyc; model[a] = d;
    @(negedge clk); shReq = 0; shWrite = 0;
  endtask

  // p: 1 = read port 0, 2 = read port 1, 3 = shared port read
  task automatic doRd(input int p, input int a, output int g);
    if (p == 1) begin rd0Req = 1; rd0Addr = AW'(a); end
    else if (p == 2) begin rd1Req = 1; rd1Addr = AW'(a); end
    else begin shReq = 1; shWrite = 0; shAddr = AW'(a); end
    #1;
    while (!((p == 1 && rd0Gnt) || (p == 2 && rd1Gnt) || (p == 3 && shGnt))) begin
      @(negedge clk); #1;
    end
    g = cyc;
    dueQ[p-1].push_back(cyc + BUSY);
    datQ[p-1].push_back(model[a]);
    @(negedge clk);
    if (p == 1) rd0Req = 0; else if (p == 2) rd1Req = 0; else shReq = 0;
  endtask

  task automatic rdRange(input int p, input int lo, input int hi);
    int g;
    for (int b = 0; b < 4; b++)
      for (int s = lo; s < hi; s++) doRd(p, s * 4 + b, g);
  endtask

  // Return monitor: exact cycle, data, order and port isolation (R8, R9).
  always @(negedge clk) begin
    logic [2:0]    vv;
    logic [DW-1:0] dd [3];
    int            due;
    logic [DW-1:0] e;
    if (rstN) begin
      vv = {shValid, rd1Valid, rd0Valid};
      dd[0] = rd0Data; dd[1] = rd1Data; dd[2] = shData;
      for (int p = 0; p < 3; p++) begin
        if (vv[p]) begin
          if (dueQ[p].size() == 0) begin
            chk(1'b0, $sformatf("R9 unexpected return on port %0d", p), dd[p], '0);
          end else begin
            due = dueQ[p].pop_front();
            e   = datQ[p].pop_front();
            chk(due == cyc, $sformatf("R8 return cycle port %0d", p), DW'(cyc), DW'(due));
            chk(dd[p] == e, $sformatf("R8/R9 return data port %0d", p), dd[p], e);
          end
        end else begin
          if (dueQ[p].size() != 0 && dueQ[p][0] <= cyc) begin
            chk(1'b0, $sformatf("R8 missing return port %0d", p), DW'(cyc), DW'(dueQ[p][0]));
            due = dueQ[p].pop_front();
            e   = datQ[p].pop_front();
          end
          if (|vv) chk(dd[p] == '0, $sformatf("R9 idle port %0d data zero", p), dd[p], '0);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errCnt++;
      $display("FAIL watchdog (all requirements): actual cycle %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int gW, g0, g1, gS, gW2, st;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset with nothing requested
    chk({wrGnt, rd0Gnt, rd1Gnt, shGnt} == 4'b0, "R1 no grant after reset",
        DW'({wrGnt, rd0Gnt, rd1Gnt, shGnt}), '0);
    chk({rd0Valid, rd1Valid, shValid} == 3'b0, "R1 no valid after reset",
        DW'({rd0Valid, rd1Valid, shValid}), '0);
    chk((rd0Data | rd1Data | shData) == '0, "R1 data zero after reset", rd0Data | rd1Data | shData, '0);

    // Sweep: beats 0..2 by the write port, beat 3 by the shared port, concurrently.
    // R7: read-back below shows that beat writes never disturb sibling beats. R10: shared writes.
    fork
      begin
        int g;
        for (int b = 0; b < 3; b++)
          for (int s = 0; s < NSW; s++) doWr(s * 4 + b, pat(s * 4 + b, 1), g);
      end
      begin
        int g;
        for (int s = 0; s < NSW; s++) doShWr(s * 4 + 3, pat(s * 4 + 3, 1), g);
      end
    join

    // Read everything back from three ports whose ranges collide bank by bank (R2, R3, R9).
    fork
      rdRange(1, 0, 96);
      rdRange(2, 96, 192);
      rdRange(3, 192, NSW);
    join
    repeat (BUSY + 4) @(negedge clk);

    // Same bank (bank 7) from all four ports at once: R2 bank = address bits [6:2].
    st = cyc;
    fork
      doWr(7 * 4 + 1, pat(7, 9), gW);
      doRd(1, 39 * 4 + 1, g0);
      doRd(2, 71 * 4 + 1, g1);
      doRd(3, 103 * 4 + 1, gS);
    join
    chk(gW == st, "R4 write port first on shared bank", DW'(gW), DW'(st));
    chk(g0 == gW + BUSY + 1, "R6 read0 after busy window", DW'(g0), DW'(gW + BUSY + 1));
    chk(g1 == g0 + BUSY + 1, "R6 read1 after busy window", DW'(g1), DW'(g0 + BUSY + 1));
    chk(gS == g1 + BUSY + 1, "R6 shared after busy window", DW'(gS), DW'(g1 + BUSY + 1));
    repeat (BUSY + 4) @(negedge clk);

    // Distinct banks 1..4: one grant per cycle in priority order (R3, R4).
    st = cyc;
    fork
      doWr(1 * 4 + 2, pat(1, 11), gW);
      doRd(1, 2 * 4 + 0, g0);
      doRd(2, 3 * 4 + 3, g1);
      doShWr(4 * 4 + 1, pat(4, 13), gS); // R10
    join
    chk(gW == st,     "R4 write granted first",  DW'(gW), DW'(st));
    chk(g0 == st + 1, "R4 read0 granted second", DW'(g0), DW'(st + 1));
    chk(g1 == st + 2, "R4 read1 granted third",  DW'(g1), DW'(st + 2));
    chk(gS == st + 3, "R3 shared granted fourth", DW'(gS), DW'(st + 3));
    repeat (BUSY + 4) @(negedge clk);

    // R5: write stalls on busy bank 9 while the shared port reaches idle bank 10.
    doWr(9 * 4, pat(9, 21), gW);
    fork
      doWr(41 * 4, pat(41, 21), gW2);
      doRd(3, 10 * 4 + 2, gS);
    join
    chk(gS == gW + 1, "R5 shared passes stalled write", DW'(gS), DW'(gW + 1));
    chk(gW2 == gW + BUSY + 1, "R6 stalled write retried after window", DW'(gW2), DW'(gW + BUSY + 1));
    repeat (BUSY + 4) @(negedge clk);

    // R7/R10 read-back of the directed writes, all beats of superwords 7, 4 and 41.
    fork
      begin int g; for (int b = 0; b < 4; b++) doRd(1, 7 * 4 + b, g); end
      begin int g; for (int b = 0; b < 4; b++) doRd(2, 4 * 4 + b, g); end
      begin int g; for (int b = 0; b < 4; b++) doRd(3, 41 * 4 + b, g); end
    join
    repeat (BUSY + 4) @(negedge clk);

    for (int p = 0; p < 3; p++)
      chk(dueQ[p].size() == 0, $sformatf("R8 all reads returned port %0d", p),
          DW'(dueQ[p].size()), '0);
    summary();
    $finish;
  end

endmodule